// File: doc/BRIEF.md
# LFSR Jump-Ahead State Calculator

This block predicts where an XNOR-feedback shift register will be after a chosen number of clock steps. It does not shift the register step by step. Because the feedback is an XNOR, one step is an affine map over GF(2) and not a linear one. Any power of that map is therefore fully described by two things: the image of the all-zero state, and the image of each single-bit state. The block keeps one such description for every power-of-two distance, from 1 step up to 2^(W-1) steps. A request is answered by composing the descriptions whose bits are set in the skip count.

After reset the block fills its own table. Level 0 comes from a one-step model of the register, which is evaluated on the zero vector and on every unit vector. Each higher level is then made by passing the previous level's stored vectors through that level twice. Once the table is ready, a caller pulses `start` with a state, a count and a direction. A backward request of N steps becomes a forward request of (2^W-1)-N steps. The block walks the count bits from lowest to highest, one bit per clock. It then pulses `done` and holds the result.

Top module: `lfsr_jump_calc`

## Requirements
- R1: After reset `busy` is high and `done` is low while the table is built. `busy` falls exactly W clock edges after reset is released (W = state width, default 5).
- R2: With the default parameters, a forward skip of 4 from 5'h00, 5'h01, 5'h02, 5'h04, 5'h08 and 5'h10 gives 5'h0C, 5'h19, 5'h07, 5'h0E, 5'h09 and 5'h06.
- R3: One step is next = {s[W-2:0], fb}, where fb = NOT(XOR of the bits of s selected by the TAPS mask, default 5'b10010). So the all-zero state advances to 5'h01 and never to itself.
- R4: With `backward`=0, the result equals the input state single-stepped `skip_in` times, for every state and every count from 0 to 2^W-1.
- R5: A skip count of zero returns the input state unchanged.
- R6: With `backward`=1, the result equals the input stepped forward ((2^W-1) - `skip_in`) mod (2^W-1) times. For a state on the main cycle, this is the state `skip_in` steps earlier.
- R7: An accepted `start` is followed, exactly W clocks later, by a `done` pulse one cycle wide. `busy` is high in between. `state_out` changes only in the cycle `done` is high and holds until the next `done`.
- R8: `start` is ignored while `busy` is high, during the table build and during a calculation. The inputs are sampled only in the accepted cycle.
- R9: The all-ones state, which the XNOR feedback leaves fixed, stays all-ones for any skip count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| start | input | 1 | Request pulse, taken when `busy` is low |
| state_in | input | W | Starting register state |
| skip_in | input | W | Number of steps to jump |
| backward | input | 1 | 1: jump backward by `skip_in` steps |
| busy | output | 1 | Table build or calculation in progress |
| done | output | 1 | One-cycle pulse when `state_out` is updated |
| state_out | output | W | Resulting register state |

## Verification
Several properties are checked on every cycle by the assertions. `done` is a single-cycle pulse that never coincides with `busy`, the result register moves only with `done`, the table-ready flag never drops, the level-0 image of zero is nonzero, and a running calculation advances its level index without being restarted by `start`. The arithmetic is visible only through the bench's scenarios, which compare each result against a behavioural single-step model. These scenarios cover the six 4-step values, zero and full-period counts, backward jumps, the all-ones fixed point, requests issued during the build and during a calculation, and a random sweep of states and counts.

// File: rtl/ljc_pkg.sv
package ljc_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ljc_step.sv
module ljc_step #(
  parameter int          W    = 5,
  parameter logic [W-1:0] TAPS = 'b10010
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);

  logic fb;

  // XNOR of the tapped bits; the zero state therefore feeds a one
  assign fb  = ~(^(cur & TAPS));
  assign nxt = {cur[W-2:0], fb};

endmodule

// File: rtl/ljc_apply.sv
module ljc_apply #(
  parameter int W = 5
) (
  input  logic [W-1:0]        base,
  input  logic [W-1:0][W-1:0] img,
  input  logic [W-1:0]        vec,
  output logic [W-1:0]        res
);

  // Affine map: start from image of zero, add each bit's contribution
  always_comb begin
    res = base;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        res = res ^ img[i] ^ base;
      end
    end
  end

endmodule

// File: rtl/ljc_table.sv
module ljc_table #(
  parameter int           W    = 5,
  parameter logic [W-1:0] TAPS = 'b10010,
  localparam int          LV   = W,
  localparam int          LVW  = ljc_pkg::idx_width(LV)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LVW-1:0]      rd_lvl,
  output logic [W-1:0]        rd_base,
  output logic [W-1:0][W-1:0] rd_img,
  output logic                ready
);

  logic [LV-1:0][W-1:0]        base_q;
  logic [LV-1:0][W-1:0][W-1:0] img_q;

  logic [LVW-1:0] bcnt_q, bcnt_d;
  logic           ready_q, ready_d;
  logic           wr_en;
  logic [LVW-1:0] src_lvl;

  logic [W-1:0]        src_base;
  logic [W-1:0][W-1:0] src_img;

  logic [W-1:0]        l0_base;
  logic [W-1:0][W-1:0] l0_img;

  logic [W:0][W-1:0]   mid_v;
  logic [W:0][W-1:0]   dbl_v;

  logic [W-1:0]        new_base;
  logic [W-1:0][W-1:0] new_img;

  // Read port serves the build (previous level) or the caller
  assign src_lvl  = ready_q ? rd_lvl :
                    ((bcnt_q == '0) ? '0 : bcnt_q - 1'b1);
  assign src_base = base_q[src_lvl];
  assign src_img  = img_q[src_lvl];
  assign rd_base  = src_base;
  assign rd_img   = src_img;
  assign ready    = ready_q;

  // Level 0: one-step model on zero and on each unit vector
  ljc_step #(.W(W), .TAPS(TAPS)) u_step_zero (
    .cur ('0),
    .nxt (l0_base)
  );

  for (genvar i = 0; i < W; i++) begin : g_unit
    localparam logic [W-1:0] UNIT_V = W'(1) << i;
    ljc_step #(.W(W), .TAPS(TAPS)) u_step_unit (
      .cur (UNIT_V),
      .nxt (l0_img[i])
    );
  end

  // Higher levels: push zero and each unit vector through the
  // previous level twice (j = 0 is the zero vector)
  for (genvar j = 0; j <= W; j++) begin : g_dbl
    localparam logic [W:0]   WIDE_V = (W+1)'(1) << j;
    localparam logic [W-1:0] SRC_V  = WIDE_V[W:1];
    ljc_apply #(.W(W)) u_first (
      .base (src_base),
      .img  (src_img),
      .vec  (SRC_V),
      .res  (mid_v[j])
    );
    ljc_apply #(.W(W)) u_second (
      .base (src_base),
      .img  (src_img),
      .vec  (mid_v[j]),
      .res  (dbl_v[j])
    );
  end

  always_comb begin
    new_base = (bcnt_q == '0) ? l0_base : dbl_v[0];
    for (int i = 0; i < W; i++) begin
      new_img[i] = (bcnt_q == '0) ? l0_img[i] : dbl_v[i+1];
    end
  end

  always_comb begin
    bcnt_d  = bcnt_q;
    ready_d = ready_q;
    wr_en   = !ready_q;
    if (!ready_q) begin
      if (bcnt_q == LVW'(LV-1)) begin
        ready_d = 1'b1;
      end else begin
        bcnt_d = bcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      bcnt_q  <= bcnt_d;
      ready_q <= ready_d;
    end
  end

  // Table storage: data only, written under its enable
  always_ff @(posedge clk) begin
    if (wr_en) begin
      base_q[bcnt_q] <= new_base;
      img_q[bcnt_q]  <= new_img;
    end
  end

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> ready_q); // R1

  AST_ZERO_NOT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> (base_q[0] != '0)); // R3

  AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> (rd_lvl < LVW'(LV))); // R4

endmodule

// File: rtl/lfsr_jump_calc.sv
module lfsr_jump_calc #(
  parameter int           W    = 5,
  parameter logic [W-1:0] TAPS = 'b10010,
  localparam int          LV   = W,
  localparam int          LVW  = ljc_pkg::idx_width(LV),
  localparam logic [W-1:0] PERIOD = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] state_in,
  input  logic [W-1:0] skip_in,
  input  logic         backward,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] state_out
);

  import ljc_pkg::*;

  phase_e         phase_q, phase_d;
  logic [LVW-1:0] idx_q, idx_d;
  logic [W-1:0]   cnt_q, cnt_d;
  logic [W-1:0]   acc_q, acc_d;
  logic [W-1:0]   out_q, out_d;
  logic           done_q, done_d;

  logic                tbl_ready;
  logic [W-1:0]        lvl_base;
  logic [W-1:0][W-1:0] lvl_img;
  logic [W-1:0]        stepped;
  logic [W-1:0]        eff_cnt;
  logic [W-1:0]        after_lvl;
  logic                accept;

  ljc_table #(.W(W), .TAPS(TAPS)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_lvl  (idx_q),
    .rd_base (lvl_base),
    .rd_img  (lvl_img),
    .ready   (tbl_ready)
  );

  ljc_apply #(.W(W)) u_apply (
    .base (lvl_base),
    .img  (lvl_img),
    .vec  (acc_q),
    .res  (stepped)
  );

  // Backward by N equals forward by PERIOD - N, folded into [0, PERIOD)
  always_comb begin
    if (!backward) begin
      eff_cnt = skip_in;
    end else if ((skip_in == '0) || (skip_in == PERIOD)) begin
      eff_cnt = '0;
    end else begin
      eff_cnt = PERIOD - skip_in;
    end
  end

  assign accept    = start && tbl_ready && (phase_q == PH_IDLE);
  assign after_lvl = cnt_q[idx_q] ? stepped : acc_q;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    out_d   = out_q;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          phase_d = PH_RUN;
          idx_d   = '0;
          cnt_d   = eff_cnt;
          acc_d   = state_in;
        end
      end
      PH_RUN: begin
        acc_d = after_lvl;
        if (idx_q == LVW'(LV-1)) begin
          phase_d = PH_IDLE;
          out_d   = after_lvl;
          done_d  = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
      out_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
      out_q   <= out_d;
      done_q  <= done_d;
    end
  end

  assign busy      = !tbl_ready || (phase_q == PH_RUN);
  assign done      = done_q;
  assign state_out = out_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(out_q)); // R7

  AST_RUN_NOT_RESTARTED: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_RUN) && (idx_q != LVW'(LV-1)))
      |=> ((phase_q == PH_RUN) && (idx_q == $past(idx_q) + 1'b1))); // R8

endmodule

// File: tb/lfsr_jump_calc_tb.sv
module lfsr_jump_calc_tb;

  localparam int          W    = 5;
  localparam int          LV   = W;
  localparam int          PER  = (1 << W) - 1;
  localparam logic [W-1:0] TAPS = 5'b10010;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [W-1:0] state_in;
  logic [W-1:0] skip_in;
  logic         backward;
  logic         busy;
  logic         done;
  logic [W-1:0] state_out;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  lfsr_jump_calc #(.W(W), .TAPS(TAPS)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .state_in  (state_in),
    .skip_in   (skip_in),
    .backward  (backward),
    .busy      (busy),
    .done      (done),
    .state_out (state_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Behavioural model of one register step (R3)
  function automatic logic [W-1:0] ref_step(input logic [W-1:0] s);
    int ones = 0;
    for (int i = 0; i < W; i++) if (TAPS[i] && s[i]) ones++;
    return {s[W-2:0], ((ones % 2) == 0)};
  endfunction

  function automatic logic [W-1:0] ref_fwd(input logic [W-1:0] s, input int n);
    logic [W-1:0] v = s;
    for (int k = 0; k < n; k++) v = ref_step(v);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  // Issue one request, compare done timing on every clock, then the result
  task automatic run_jump(input logic [W-1:0] s, input logic [W-1:0] n,
                          input logic bk, input bit poke, input string req);
    logic [W-1:0] exp;
    int           eff;
    int           tfail = 0;
    eff = bk ? ((PER - int'(n)) % PER) : int'(n);
    exp = ref_fwd(s, eff);
    @(negedge clk);
    start = 1'b1; state_in = s; skip_in = n; backward = bk;
    @(negedge clk);
    start = poke; state_in = ~s; skip_in = ~n; backward = ~bk;
    for (int c = 1; c <= LV; c++) begin
      @(negedge clk);
      if (done !== (c == LV)) tfail++;
      if ((c < LV) && !busy) tfail++;
      start = poke && (c < LV);
    end
    check(tfail == 0, "R7", tfail, 0);
    check(state_out == exp, req, state_out, exp);
  endtask

  initial begin
    int  bcyc;
    bit  early_done;
    logic [W-1:0] held;
    rst_n = 1'b0; start = 1'b0; state_in = '0; skip_in = '0; backward = 1'b0;
    repeat (3) @(negedge clk);
    check(busy === 1'b1, "R1", busy, 1);
    check(done === 1'b0, "R1", done, 0);
    rst_n = 1'b1;
    // R8: request held high during the build must be ignored
    start = 1'b1; state_in = 5'h03; skip_in = 5'h07;
    bcyc = 0; early_done = 0;
    while (bcyc < 40) begin
      @(negedge clk);
      bcyc++;
      if (done) early_done = 1;
      if (!busy) break;
    end
    start = 1'b0;
    check(bcyc == LV, "R1", bcyc, LV);
    repeat (3) begin
      @(negedge clk);
      if (done) early_done = 1;
    end
    check(!early_done && !busy, "R8", early_done, 0);

    // R3: zero advances by one step to 5'h01
    run_jump(5'h00, 5'd1, 1'b0, 1'b0, "R3");
    // R2: stored 4-step values
    run_jump(5'h00, 5'd4, 1'b0, 1'b0, "R2");
    check(state_out == 5'h0C, "R2", state_out, 5'h0C);
    run_jump(5'h01, 5'd4, 1'b0, 1'b0, "R2");
    check(state_out == 5'h19, "R2", state_out, 5'h19);
    run_jump(5'h02, 5'd4, 1'b0, 1'b0, "R2");
    check(state_out == 5'h07, "R2", state_out, 5'h07);
    run_jump(5'h04, 5'd4, 1'b0, 1'b0, "R2");
    check(state_out == 5'h0E, "R2", state_out, 5'h0E);
    run_jump(5'h08, 5'd4, 1'b0, 1'b0, "R2");
    check(state_out == 5'h09, "R2", state_out, 5'h09);
    run_jump(5'h10, 5'd4, 1'b0, 1'b0, "R2");
    check(state_out == 5'h06, "R2", state_out, 5'h06);

    // R5: zero count, both directions
    run_jump(5'h15, 5'd0, 1'b0, 1'b0, "R5");
    check(state_out == 5'h15, "R5", state_out, 5'h15);
    run_jump(5'h0A, 5'd0, 1'b1, 1'b0, "R5");
    check(state_out == 5'h0A, "R5", state_out, 5'h0A);

    // R4: mixed levels and full period
    run_jump(5'h0B, 5'd21, 1'b0, 1'b0, "R4");
    run_jump(5'h06, 5'd31, 1'b0, 1'b0, "R4");
    check(state_out == 5'h06, "R4", state_out, 5'h06);
    run_jump(5'h1E, 5'd16, 1'b0, 1'b0, "R4");

    // R6: backward jumps undo forward ones
    run_jump(5'h0C, 5'd4, 1'b1, 1'b0, "R6");
    check(state_out == 5'h00, "R6", state_out, 5'h00);
    run_jump(5'h13, 5'd10, 1'b1, 1'b0, "R6");
    run_jump(5'h07, 5'd31, 1'b1, 1'b0, "R6");

    // R9: all-ones fixed point
    run_jump(5'h1F, 5'd13, 1'b0, 1'b0, "R9");
    check(state_out == 5'h1F, "R9", state_out, 5'h1F);
    run_jump(5'h1F, 5'd5, 1'b1, 1'b0, "R9");

    // R8: start held during a calculation is ignored
    run_jump(5'h09, 5'd11, 1'b0, 1'b1, "R8");
    @(negedge clk);
    check(!busy && !done, "R8", busy, 0);

    // R7: result held while idle
    held = state_out;
    repeat (4) @(negedge clk);
    check(state_out == held && !done, "R7", state_out, held);

    // R4 / R6: random sweep
    for (int t = 0; t < 60; t++) begin
      run_jump(W'($urandom), W'($urandom), 1'($urandom), 1'b0,
               (t % 2 == 0) ? "R4" : "R6");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule